// File: doc/BRIEF.md
# Erase-Count Window Block Allocator

This block chooses physical flash blocks for incoming writes from the erase count it keeps for every block in a small array. A write request names its data class. Hot data receives the least-worn free block that still sits safely inside the erase-count window. Cold data receives the most-worn free block, so that cold data parks on the tired blocks and the young ones stay in circulation. A release port hands blocks back to the free pool. An erase-notify port adds one to a block's count.

The allocator follows the lowest live erase count (the window floor). It also keeps an adaptive window width `t` and a hot-region boundary `m`. `t` narrows as the mean erase count rises. `m` drifts with the position at which erases land inside the window. When any live block climbs to the top level of the window, the allocator raises a migration request. That request names an in-use block that sits at the floor, whose cold contents should move to a worn block. The block only takes decisions: the data copy, garbage collection and address mapping belong to other blocks.

Top module: `ec_window_alloc`

## Requirements
- R1: After synchronous reset every block is free with a count of zero, `min_ec` and `mean_ec` are 0, `win_t` equals T_INIT, `hot_m` equals T_INIT/2, `req_ready` is 1, and `rsp_valid`, `mig_req` and `worn_mask` are 0.
- R2: A hot request (`req_cold`=0) returns the free, non-worn block with the smallest erase count. Equal counts resolve to the lowest block index.
- R3: A cold request (`req_cold`=1) returns the free, non-worn block with the largest erase count, with no window limit. Equal counts resolve to the lowest block index.
- R4: A granted block leaves the free pool and is not offered again until `rel_valid` returns it with `rel_blk`.
- R5: When no block qualifies, the response carries `rsp_err`=1 and `rsp_blk`=0, and the free pool is unchanged.
- R6: A request is taken on a clock edge where `req_valid` and `req_ready` are both high. `rsp_valid` rises on that edge and stays high, with `rsp_blk` and `rsp_err` steady, until an edge with `rsp_ready` high. `req_ready` is low while a response is pending.
- R7: Each `ers_valid` pulse adds one to the count of block `ers_blk`. `min_ec` gives the smallest count among non-worn blocks one cycle after the erase. `mean_ec` gives the sum of the non-worn increments divided by NUM_BLK, one cycle after that.
- R8: A block whose offset above the floor is `win_t`-1 or more is never handed out for hot data.
- R9: An erase on a block whose offset before the erase is `win_t`-2 or more lowers `hot_m` by one, with a floor of 1. Otherwise, an erase on a block at offset 0 raises `hot_m` by one, with a ceiling of `win_t`-1.
- R10: Each time `mean_ec` reaches the next multiple of MEAN_STEP, `win_t` drops by a tenth of its value (at least 1) but not below T_MIN. `hot_m` is then clamped to `win_t`-1.
- R11: `mig_req` is 1 while some non-worn block has an offset of `win_t`-1 or more and an in-use, non-worn block sits at the floor. `mig_blk` names the lowest such in-use block.
- R12: A block whose count reaches WORN_LIMIT shows in `worn_mask`, stops counting, is never granted again (even after a release), and is left out of the floor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Allocation request present |
| req_cold | input | 1 | Data class: 0 hot, 1 cold |
| req_ready | output | 1 | Request can be taken |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Consumer takes the response |
| rsp_blk | output | BLK_W | Chosen block index (0 on error) |
| rsp_err | output | 1 | No block could be chosen |
| rel_valid | input | 1 | Return a block to the free pool |
| rel_blk | input | BLK_W | Block to return |
| ers_valid | input | 1 | Erase notification |
| ers_blk | input | BLK_W | Erased block |
| min_ec | output | EC_W | Window floor (lowest live count) |
| mean_ec | output | EC_W | Mean erase count |
| win_t | output | T_W | Current window width |
| hot_m | output | T_W | Hot-region boundary |
| mig_req | output | 1 | Cold-data migration requested |
| mig_blk | output | BLK_W | In-use floor block to migrate from |
| worn_mask | output | NUM_BLK | One bit per worn-out block |

## Verification
The bench builds equal-count ties on purpose. A selector that scanned from the top index, or that used a non-strict compare, would return a later block than the lowest one. It pushes one block to the top level of the window, which separates a correct exclusion from an off-by-one error: such an error would still hand that block to hot data, or would raise the migration request one erase too early. Long round-robin erase runs drive the window width through several shrink steps and against its floor, which exposes a wrong step size, a missing clamp of the hot boundary, or a width that keeps falling. A block driven to the wear limit must stay out of every later grant, even after a release, and a design that saturated or compared wrongly would grant it again.

// File: rtl/ecw_pkg.sv
package ecw_pkg;

  typedef enum logic {
    CLS_HOT  = 1'b0,
    CLS_COLD = 1'b1
  } data_class_e;

  // linear narrowing step: one tenth of the width, never less than one
  function automatic int tenth_step(input int width);
    int s;
    s = width / 10;
    if (s == 0) s = 1;
    return s;
  endfunction

endpackage

// File: rtl/ecw_count_table.sv
module ecw_count_table #(
  parameter int NUM_BLK    = 16,
  parameter int EC_W       = 17,
  parameter int WORN_LIMIT = 100000,
  localparam int BLK_W     = $clog2(NUM_BLK)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    ers_valid,
  input  logic [BLK_W-1:0]        ers_blk,
  input  logic                    grant_valid,
  input  logic [BLK_W-1:0]        grant_blk,
  input  logic                    rel_valid,
  input  logic [BLK_W-1:0]        rel_blk,
  output logic [NUM_BLK*EC_W-1:0] ec_flat,
  output logic [NUM_BLK-1:0]      free_vec,
  output logic [NUM_BLK-1:0]      worn_vec
);

  localparam logic [EC_W-1:0] LIMIT = EC_W'(WORN_LIMIT);

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic [EC_W-1:0] cnt_q;
    logic            free_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        cnt_q  <= '0;
        free_q <= 1'b1;
      end else begin
        if (ers_valid && (ers_blk == BLK_W'(g)) && (cnt_q < LIMIT))
          cnt_q <= cnt_q + 1'b1;
        if (grant_valid && (grant_blk == BLK_W'(g)))
          free_q <= 1'b0;
        if (rel_valid && (rel_blk == BLK_W'(g)))
          free_q <= 1'b1;
      end
    end

    assign ec_flat[g*EC_W +: EC_W] = cnt_q;
    assign free_vec[g]             = free_q;
    assign worn_vec[g]             = (cnt_q >= LIMIT);
  end

endmodule

// File: rtl/ecw_floor_scan.sv
module ecw_floor_scan #(
  parameter int NUM_BLK = 16,
  parameter int EC_W    = 17
) (
  input  logic [NUM_BLK*EC_W-1:0] ec_flat,
  input  logic [NUM_BLK-1:0]      worn_vec,
  output logic [EC_W-1:0]         floor_ec
);

  logic            seen;
  logic [EC_W-1:0] best;
  logic [EC_W-1:0] cur;

  always_comb begin
    seen = 1'b0;
    best = '0;
    cur  = '0;
    for (int i = 0; i < NUM_BLK; i++) begin
      cur = ec_flat[i*EC_W +: EC_W];
      if (!worn_vec[i] && (!seen || (cur < best))) begin
        seen = 1'b1;
        best = cur;
      end
    end
    floor_ec = best;
  end

endmodule

// File: rtl/ecw_pick.sv
module ecw_pick #(
  parameter int NUM_BLK = 16,
  parameter int EC_W    = 17,
  parameter int T_W     = 7,
  localparam int BLK_W  = $clog2(NUM_BLK)
) (
  input  logic [NUM_BLK*EC_W-1:0] ec_flat,
  input  logic [NUM_BLK-1:0]      free_vec,
  input  logic [NUM_BLK-1:0]      worn_vec,
  input  logic [EC_W-1:0]         floor_ec,
  input  logic [T_W-1:0]          width_t,
  output logic                    hot_ok,
  output logic [BLK_W-1:0]        hot_idx,
  output logic                    cold_ok,
  output logic [BLK_W-1:0]        cold_idx
);

  logic [EC_W-1:0] top_off;
  logic [EC_W-1:0] hot_best;
  logic [EC_W-1:0] cold_best;
  logic [EC_W-1:0] cur;
  logic            usable;

  always_comb begin
    top_off   = EC_W'(width_t) - 1'b1;
    hot_ok    = 1'b0;
    hot_idx   = '0;
    hot_best  = '0;
    cold_ok   = 1'b0;
    cold_idx  = '0;
    cold_best = '0;
    cur       = '0;
    usable    = 1'b0;
    for (int i = 0; i < NUM_BLK; i++) begin
      cur    = ec_flat[i*EC_W +: EC_W];
      usable = free_vec[i] && !worn_vec[i];
      // hot: least worn, strictly below the window top level
      if (usable && ((cur - floor_ec) < top_off) && (!hot_ok || (cur < hot_best))) begin
        hot_ok   = 1'b1;
        hot_idx  = BLK_W'(i);
        hot_best = cur;
      end
      // cold: most worn anywhere
      if (usable && (!cold_ok || (cur > cold_best))) begin
        cold_ok   = 1'b1;
        cold_idx  = BLK_W'(i);
        cold_best = cur;
      end
    end
  end

endmodule

// File: rtl/ecw_window.sv
module ecw_window #(
  parameter int NUM_BLK   = 16,
  parameter int EC_W      = 17,
  parameter int T_INIT    = 64,
  parameter int T_MIN     = 8,
  parameter int MEAN_STEP = 1024,
  localparam int BLK_W    = $clog2(NUM_BLK),
  localparam int T_W      = $clog2(T_INIT + 1),
  localparam int SUM_W    = EC_W + BLK_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [NUM_BLK*EC_W-1:0] ec_flat,
  input  logic [NUM_BLK-1:0]      free_vec,
  input  logic [NUM_BLK-1:0]      worn_vec,
  input  logic [EC_W-1:0]         floor_ec,
  input  logic                    ers_valid,
  input  logic [BLK_W-1:0]        ers_blk,
  output logic [EC_W-1:0]         floor_q,
  output logic [EC_W-1:0]         mean_q,
  output logic [T_W-1:0]          t_q,
  output logic [T_W-1:0]          m_q,
  output logic                    mig_q,
  output logic [BLK_W-1:0]        mig_blk_q
);

  logic [SUM_W-1:0] sum_q;
  logic [EC_W:0]    next_at_q;
  logic             live_ers;
  logic [EC_W-1:0]  ers_off;
  logic             shrink;
  logic [T_W-1:0]   t_nx;
  logic [T_W-1:0]   m_nx;
  int               ti;
  int               mi;
  int               oi;
  int               tn;

  assign live_ers = ers_valid && !worn_vec[ers_blk];
  assign ers_off  = ec_flat[ers_blk*EC_W +: EC_W] - floor_ec;
  assign shrink   = ({1'b0, mean_q} >= next_at_q) && (int'(t_q) > T_MIN);

  always_comb begin
    ti = int'(t_q);
    mi = int'(m_q);
    oi = int'(ers_off);
    if (live_ers) begin
      if (oi + 1 >= ti - 1) begin
        if (mi > 1) mi = mi - 1;
      end else if ((oi == 0) && (mi < ti - 1)) begin
        mi = mi + 1;
      end
    end
    tn = ti;
    if (shrink) begin
      tn = ti - ecw_pkg::tenth_step(ti);
      if (tn < T_MIN) tn = T_MIN;
    end
    if (mi > tn - 1) mi = tn - 1;
    t_nx = T_W'(tn);
    m_nx = T_W'(mi);
  end

  // migration pressure and source pick
  logic [EC_W-1:0]  top_off;
  logic [EC_W-1:0]  cur;
  logic             pressure;
  logic             src_ok;
  logic [BLK_W-1:0] src_idx;

  always_comb begin
    top_off  = EC_W'(t_q) - 1'b1;
    pressure = 1'b0;
    src_ok   = 1'b0;
    src_idx  = '0;
    cur      = '0;
    for (int i = 0; i < NUM_BLK; i++) begin
      cur = ec_flat[i*EC_W +: EC_W];
      if (!worn_vec[i] && ((cur - floor_ec) >= top_off))
        pressure = 1'b1;
      if (!src_ok && !free_vec[i] && !worn_vec[i] && (cur == floor_ec)) begin
        src_ok  = 1'b1;
        src_idx = BLK_W'(i);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sum_q     <= '0;
      mean_q    <= '0;
      next_at_q <= (EC_W+1)'(MEAN_STEP);
      t_q       <= T_W'(T_INIT);
      m_q       <= T_W'(T_INIT / 2);
      floor_q   <= '0;
      mig_q     <= 1'b0;
      mig_blk_q <= '0;
    end else begin
      if (live_ers) sum_q <= sum_q + 1'b1;
      mean_q    <= EC_W'(sum_q >> BLK_W);
      if (shrink) next_at_q <= next_at_q + (EC_W+1)'(MEAN_STEP);
      t_q       <= t_nx;
      m_q       <= m_nx;
      floor_q   <= floor_ec;
      mig_q     <= pressure && src_ok;
      mig_blk_q <= src_idx;
    end
  end

endmodule

// File: rtl/ec_window_alloc.sv
module ec_window_alloc #(
  parameter int NUM_BLK    = 16,
  parameter int EC_W       = 17,
  parameter int WORN_LIMIT = 100000,
  parameter int T_INIT     = 64,
  parameter int T_MIN      = 8,
  parameter int MEAN_STEP  = 1024,
  localparam int BLK_W     = $clog2(NUM_BLK),
  localparam int T_W       = $clog2(T_INIT + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               req_valid,
  input  logic               req_cold,
  output logic               req_ready,
  output logic               rsp_valid,
  input  logic               rsp_ready,
  output logic [BLK_W-1:0]   rsp_blk,
  output logic               rsp_err,
  input  logic               rel_valid,
  input  logic [BLK_W-1:0]   rel_blk,
  input  logic               ers_valid,
  input  logic [BLK_W-1:0]   ers_blk,
  output logic [EC_W-1:0]    min_ec,
  output logic [EC_W-1:0]    mean_ec,
  output logic [T_W-1:0]     win_t,
  output logic [T_W-1:0]     hot_m,
  output logic               mig_req,
  output logic [BLK_W-1:0]   mig_blk,
  output logic [NUM_BLK-1:0] worn_mask
);

  logic [NUM_BLK*EC_W-1:0] ec_flat;
  logic [NUM_BLK-1:0]      free_vec;
  logic [NUM_BLK-1:0]      worn_vec;
  logic [EC_W-1:0]         floor_ec;
  logic                    hot_ok, cold_ok;
  logic [BLK_W-1:0]        hot_idx, cold_idx;
  logic                    take;
  logic                    pick_ok;
  logic [BLK_W-1:0]        pick_idx;
  logic                    rsp_valid_q;
  logic [BLK_W-1:0]        rsp_blk_q;
  logic                    rsp_err_q;

  assign take     = req_valid && !rsp_valid_q;
  assign pick_ok  = (req_cold == ecw_pkg::CLS_COLD) ? cold_ok  : hot_ok;
  assign pick_idx = (req_cold == ecw_pkg::CLS_COLD) ? cold_idx : hot_idx;

  ecw_count_table #(
    .NUM_BLK(NUM_BLK), .EC_W(EC_W), .WORN_LIMIT(WORN_LIMIT)
  ) i_table (
    .clk(clk), .rst(rst),
    .ers_valid(ers_valid), .ers_blk(ers_blk),
    .grant_valid(take && pick_ok), .grant_blk(pick_idx),
    .rel_valid(rel_valid), .rel_blk(rel_blk),
    .ec_flat(ec_flat), .free_vec(free_vec), .worn_vec(worn_vec)
  );

  ecw_floor_scan #(.NUM_BLK(NUM_BLK), .EC_W(EC_W)) i_floor (
    .ec_flat(ec_flat), .worn_vec(worn_vec), .floor_ec(floor_ec)
  );

  ecw_pick #(.NUM_BLK(NUM_BLK), .EC_W(EC_W), .T_W(T_W)) i_pick (
    .ec_flat(ec_flat), .free_vec(free_vec), .worn_vec(worn_vec),
    .floor_ec(floor_ec), .width_t(win_t),
    .hot_ok(hot_ok), .hot_idx(hot_idx),
    .cold_ok(cold_ok), .cold_idx(cold_idx)
  );

  ecw_window #(
    .NUM_BLK(NUM_BLK), .EC_W(EC_W), .T_INIT(T_INIT),
    .T_MIN(T_MIN), .MEAN_STEP(MEAN_STEP)
  ) i_window (
    .clk(clk), .rst(rst),
    .ec_flat(ec_flat), .free_vec(free_vec), .worn_vec(worn_vec),
    .floor_ec(floor_ec), .ers_valid(ers_valid), .ers_blk(ers_blk),
    .floor_q(min_ec), .mean_q(mean_ec), .t_q(win_t), .m_q(hot_m),
    .mig_q(mig_req), .mig_blk_q(mig_blk)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid_q <= 1'b0;
      rsp_blk_q   <= '0;
      rsp_err_q   <= 1'b0;
    end else if (take) begin
      rsp_valid_q <= 1'b1;
      rsp_blk_q   <= pick_ok ? pick_idx : '0;
      rsp_err_q   <= !pick_ok;
    end else if (rsp_valid_q && rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign req_ready = !rsp_valid_q;
  assign rsp_valid = rsp_valid_q;
  assign rsp_blk   = rsp_blk_q;
  assign rsp_err   = rsp_err_q;
  assign worn_mask = worn_vec;

endmodule

// File: rtl/ec_window_alloc_chk.sv
module ec_window_alloc_chk #(
  parameter int NUM_BLK    = 16,
  parameter int EC_W       = 17,
  parameter int T_INIT     = 64,
  parameter int T_MIN      = 8,
  localparam int BLK_W     = $clog2(NUM_BLK),
  localparam int T_W       = $clog2(T_INIT + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               rsp_ready,
  input logic [BLK_W-1:0]   rsp_blk,
  input logic               rsp_err,
  input logic               ers_valid,
  input logic [T_W-1:0]     win_t,
  input logic [T_W-1:0]     hot_m,
  input logic               mig_req,
  input logic [BLK_W-1:0]   mig_blk,
  input logic [NUM_BLK-1:0] worn_mask
);

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_blk) && $stable(rsp_err)); // R6
  AST_READY_LOW: assert property (@(posedge clk) disable iff (rst)
    rsp_valid |-> !req_ready); // R6
  AST_ERR_INDEX: assert property (@(posedge clk) disable iff (rst)
    rsp_valid && rsp_err |-> rsp_blk == '0); // R5
  AST_M_RANGE: assert property (@(posedge clk) disable iff (rst)
    hot_m >= T_W'(1) && hot_m < win_t); // R9
  AST_T_NARROW: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> win_t <= $past(win_t) && int'(win_t) >= T_MIN); // R10
  AST_GRANT_LIVE: assert property (@(posedge clk) disable iff (rst)
    $rose(rsp_valid) && !rsp_err && !$past(ers_valid) |-> !worn_mask[rsp_blk]); // R12
  AST_MIG_LIVE: assert property (@(posedge clk) disable iff (rst)
    mig_req && !$past(ers_valid) |-> !worn_mask[mig_blk]); // R11

endmodule

bind ec_window_alloc ec_window_alloc_chk #(
  .NUM_BLK(NUM_BLK), .EC_W(EC_W), .T_INIT(T_INIT), .T_MIN(T_MIN)
) i_chk (.*);

// File: tb/test_ec_window_alloc.sv
module test_ec_window_alloc;

  localparam int NB    = 4;
  localparam int ECW   = 8;
  localparam int WORN  = 60;
  localparam int TI    = 12;
  localparam int TM    = 8;
  localparam int STEP  = 8;
  localparam int BW    = $clog2(NB);
  localparam int TW    = $clog2(TI + 1);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_cold = 1'b0, rsp_ready = 1'b0;
  logic          rel_valid = 1'b0, ers_valid = 1'b0;
  logic [BW-1:0] rel_blk = '0, ers_blk = '0;
  logic          req_ready, rsp_valid, rsp_err, mig_req;
  logic [BW-1:0] rsp_blk, mig_blk;
  logic [ECW-1:0] min_ec, mean_ec;
  logic [TW-1:0] win_t, hot_m;
  logic [NB-1:0] worn_mask;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  ec_window_alloc #(
    .NUM_BLK(NB), .EC_W(ECW), .WORN_LIMIT(WORN),
    .T_INIT(TI), .T_MIN(TM), .MEAN_STEP(STEP)
  ) i_ec_window_alloc (.*);

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic erase(input int blk, input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); ers_valid = 1'b1; ers_blk = BW'(blk);
      @(posedge clk); #1 ers_valid = 1'b0;
    end
  endtask

  task automatic release_blk(input int blk);
    @(negedge clk); rel_valid = 1'b1; rel_blk = BW'(blk);
    @(posedge clk); #1 rel_valid = 1'b0;
  endtask

  // request, optionally stall the consumer, check the answer
  task automatic request(input string tag, input bit cold, input int hold,
                         input bit exp_err, input int exp_blk);
    @(negedge clk); req_valid = 1'b1; req_cold = cold;
    @(posedge clk); #1 req_valid = 1'b0;
    @(negedge clk);
    chk({tag, " rsp_valid"}, int'(rsp_valid), 1);
    chk({tag, " rsp_err"}, int'(rsp_err), int'(exp_err));
    chk({tag, " rsp_blk"}, int'(rsp_blk), exp_err ? 0 : exp_blk);
    for (int k = 0; k < hold; k++) begin
      @(negedge clk);
      chk({tag, " R6 held valid"}, int'(rsp_valid), 1);
      chk({tag, " R6 ready low"}, int'(req_ready), 0);
      chk({tag, " R6 held blk"}, int'(rsp_blk), exp_err ? 0 : exp_blk);
    end
    rsp_ready = 1'b1;
    @(posedge clk); #1 rsp_ready = 1'b0;
    @(negedge clk);
    chk({tag, " R6 drop"}, int'(rsp_valid), 0);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 req_ready", int'(req_ready), 1);
    chk("R1 rsp_valid", int'(rsp_valid), 0);
    chk("R1 min_ec", int'(min_ec), 0);
    chk("R1 mean_ec", int'(mean_ec), 0);
    chk("R1 win_t", int'(win_t), TI);
    chk("R1 hot_m", int'(hot_m), TI / 2);
    chk("R1 mig_req", int'(mig_req), 0);
    chk("R1 worn_mask", int'(worn_mask), 0);
  endtask

  task automatic t_hot_order();
    do_reset();
    request("R2 tie lowest", 1'b0, 0, 1'b0, 0);
    request("R2 next tie", 1'b0, 3, 1'b0, 1);
    release_blk(0);
    request("R4 release back", 1'b0, 0, 1'b0, 0);
    do_reset();
    erase(0, 2); erase(1, 1); erase(2, 1); erase(3, 3);   // counts 2,1,1,3
    settle();
    chk("R7 min_ec", int'(min_ec), 1);
    chk("R7 mean_ec", int'(mean_ec), 1);
    chk("R9 hot_m rises", int'(hot_m), 11);
    request("R2 smallest tie", 1'b0, 0, 1'b0, 1);
    request("R2 smallest 2", 1'b0, 0, 1'b0, 2);
    request("R2 smallest 3", 1'b0, 0, 1'b0, 0);
    request("R2 smallest 4", 1'b0, 0, 1'b0, 3);
    request("R5 empty hot", 1'b0, 2, 1'b1, 0);
  endtask

  task automatic t_cold_order();
    do_reset();
    erase(1, 2); erase(3, 2); erase(0, 1);                // counts 1,2,0,2
    settle();
    request("R3 largest tie", 1'b1, 0, 1'b0, 1);
    request("R3 largest 2", 1'b1, 0, 1'b0, 3);
    request("R3 largest 3", 1'b1, 0, 1'b0, 0);
    request("R2 last hot", 1'b0, 0, 1'b0, 2);
    release_blk(3);
    request("R4 cold after release", 1'b1, 0, 1'b0, 3);
    request("R5 empty cold", 1'b1, 0, 1'b1, 0);
  endtask

  task automatic t_window_top();
    do_reset();
    request("R2 seed in-use", 1'b0, 0, 1'b0, 0);
    erase(1, 10);
    settle();
    chk("R11 no pressure yet", int'(mig_req), 0);
    chk("R9 hot_m after 10", int'(hot_m), 7);
    erase(1, 1);                                          // offset 11 = t-1
    settle();
    chk("R11 mig_req", int'(mig_req), 1);
    chk("R11 mig_blk", int'(mig_blk), 0);
    chk("R9 hot_m falls", int'(hot_m), 6);
    chk("R10 win_t kept", int'(win_t), TI);
    request("R8 hot 2", 1'b0, 0, 1'b0, 2);
    request("R8 hot 3", 1'b0, 0, 1'b0, 3);
    request("R8 top excluded", 1'b0, 0, 1'b1, 0);
    request("R3 cold takes top", 1'b1, 0, 1'b0, 1);
  endtask

  task automatic rounds(input int n);
    for (int r = 0; r < n; r++)
      for (int b = 0; b < NB; b++) erase(b, 1);
  endtask

  task automatic t_shrink();
    do_reset();
    rounds(8);  settle();
    chk("R10 first step", int'(win_t), 11);
    chk("R10 m clamp 1", int'(hot_m), 10);
    rounds(8);  settle();
    chk("R10 second step", int'(win_t), 10);
    chk("R10 m clamp 2", int'(hot_m), 9);
    chk("R7 min after 16", int'(min_ec), 16);
    rounds(28); settle();
    chk("R10 floor", int'(win_t), TM);
    chk("R10 m clamp floor", int'(hot_m), TM - 1);
    chk("R7 mean 44", int'(mean_ec), 44);
  endtask

  task automatic t_worn();
    do_reset();
    erase(2, WORN + 2);
    settle();
    chk("R12 worn_mask", int'(worn_mask), 4);
    chk("R10 shrink by mean", int'(win_t), 11);
    chk("R12 min excludes worn", int'(min_ec), 0);
    request("R12 cold skips worn 1", 1'b1, 0, 1'b0, 0);
    request("R12 cold skips worn 2", 1'b1, 0, 1'b0, 1);
    request("R12 cold skips worn 3", 1'b1, 0, 1'b0, 3);
    release_blk(2);
    request("R12 worn after release", 1'b1, 0, 1'b1, 0);
    request("R12 hot also refused", 1'b0, 0, 1'b1, 0);
    erase(0, 1); erase(1, 1); erase(3, 1);
    settle();
    chk("R12 floor of live blocks", int'(min_ec), 1);
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    t_reset();
    t_hot_order();
    t_cold_order();
    t_window_top();
    t_shrink();
    t_worn();
    finish_run();
  end

endmodule